// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is a single-master I2C controller. Software drives it one byte at a time. Each command word can ask for a start condition with a 7-bit target address. It can also ask for one byte to be sent or received, mark a received byte as the final one, and close the transfer with a stop. A byte for the target is placed in the data buffer before the command is issued. A byte from the target is read from the same buffer after the command completes. Completion, a target that did not acknowledge, and the outcome of a bus recovery are kept as sticky status bits, which software clears by writing ones. A bus-busy flag shows that the bus is owned between a start and a stop.

SCL and SDA are open-drain: the block either pulls a line low or releases it. It samples both lines and shows their levels. Bit timing comes from an external tick input, and every tick advances one quarter of an SCL period. A recovery command clocks a bus whose SDA is stuck low, then either closes with a stop or reports failure.

Top module: `i2c_pkt_master`

## Requirements
- R1: A command is accepted only when bit 15 (enable) of the command word is 1 and the engine is idle. The other fields are: bits 6:0 target address, bit 7 start, bit 8 transmit, bit 9 receive, bit 10 last receive, bit 11 stop, bit 12 recover. A command with bit 15 at 0 causes no bus activity and no status change.
- R2: With start set, the engine issues a start condition (or a repeated start if the bus is held) and sends the address byte {addr, rw}, where rw is 1 for a receive command and 0 otherwise. A command without start sends no new start.
- R3: A command with start set and neither transmit nor receive performs only the address phase and its acknowledge bit.
- R4: A transmit command sends the byte held in the data buffer, MSB first. A receive command places the received byte in the data buffer, where it is readable when the command completes.
- R5: Packet-done (status bit 0) is set when each non-recovery command ends. Writing a 1 to a mask bit clears the matching status bit and leaves the others unchanged.
- R6: A NAK on the address or on a transmitted byte sets the NAK flag (status bit 1) together with packet-done. After an address NAK, the data byte is skipped and the stop, if requested, is still issued.
- R7: A stop condition is generated only when the stop flag is set. Otherwise SCL stays driven low and the bus remains held for a repeated start.
- R8: Bus-busy is 1 from a start condition until the next stop condition.
- R9: A received byte is answered with ACK (SDA low) unless last receive is set, in which case it is answered with NACK.
- R10: Recovery clocks SCL while SDA stays low. As soon as SDA is sampled high it issues a stop and sets recovered (status bit 2).
- R11: If SDA is still low after REC_PULSES (default 9) clock pulses, recovery releases both lines, issues no stop, and sets recovery-failed (status bit 3).
- R12: Both lines are driven open-drain, the sampled line levels are visible as outputs, and with the bus idle and not held neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | Quarter SCL period strobe |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 16 | Command word |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rdata | output | 8 | Data buffer contents |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 4 | Write-one-to-clear mask for status bits 3:0 |
| sts_done | output | 1 | Packet done |
| sts_nak | output | 1 | Target NAK seen |
| sts_rec_ok | output | 1 | Recovery succeeded |
| sts_rec_fail | output | 1 | Recovery failed |
| bus_busy | output | 1 | Bus owned between start and stop |
| engine_busy | output | 1 | A command is in progress |
| scl_level | output | 1 | Sampled SCL level |
| sda_level | output | 1 | Sampled SDA level |
| scl_i | input | 1 | SCL line input |
| sda_i | input | 1 | SDA line input |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |

## Verification
The assertions assume that SCL is never held low by a target, so the block's own SCL drive alone decides each phase, and that phase ticks are spaced at least two clocks apart so the sampled line is settled before it is used. The bench target model changes SDA only while SCL is low, except during the stuck-low scenarios. Its tick strobe fires once every four clocks. A new command is written only after engine_busy falls, so the stimulus never depends on how commands are dropped while the engine is busy.

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master #(
  parameter int REC_PULSES = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phase_tick,
  input  logic        cmd_we,
  input  logic [15:0] cmd_word,
  input  logic        buf_we,
  input  logic [7:0]  buf_wdata,
  output logic [7:0]  buf_rdata,
  input  logic        sts_clr_we,
  input  logic [3:0]  sts_clr_mask,
  output logic        sts_done,
  output logic        sts_nak,
  output logic        sts_rec_ok,
  output logic        sts_rec_fail,
  output logic        bus_busy,
  output logic        engine_busy,
  output logic        scl_level,
  output logic        sda_level,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_drive_low,
  output logic        sda_drive_low
);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_BIT = 3'd2,
                         S_ACK = 3'd3, S_STOP = 3'd4, S_REC = 3'd5;
  localparam int RCW = $clog2(REC_PULSES + 1);
  localparam logic [RCW-1:0] RLAST = RCW'(REC_PULSES - 1);

  logic [2:0] st, nxt, first;
  logic [1:0] ph;
  logic [2:0] bitn;
  logic [7:0] shreg, dbuf;
  logic       samp, in_addr, nak, bb;
  logic       c_tx, c_rx, c_last, c_stop, c_rec;
  logic [RCW-1:0] rcnt;
  logic       scl_q, sda_q;

  wire accept = cmd_we && cmd_word[15] && st == S_IDLE;
  wire adv    = phase_tick && st != S_IDLE;
  wire endph  = adv && ph == 2'd3;
  wire [2:0] tail = c_stop ? S_STOP : S_IDLE;

  wire f_start = cmd_word[7], f_tx = cmd_word[8], f_rx = cmd_word[9];
  wire f_stop = cmd_word[11], f_rec = cmd_word[12];

  always_comb begin
    if (f_rec)             first = S_REC;
    else if (f_start)      first = S_START;
    else if (f_tx || f_rx) first = S_BIT;
    else if (f_stop)       first = S_STOP;
    else                   first = S_IDLE;
  end

  always_comb begin
    nxt = S_IDLE;
    case (st)
      S_START: nxt = S_BIT;
      S_BIT:   nxt = (bitn == 3'd7) ? S_ACK : S_BIT;
      S_ACK:   if (in_addr && !nak && (c_tx || c_rx)) nxt = S_BIT;
               else nxt = tail;
      S_STOP:  nxt = S_IDLE;
      S_REC:   if (samp) nxt = S_STOP;
               else if (rcnt == RLAST) nxt = S_IDLE;
               else nxt = S_REC;
      default: nxt = S_IDLE;
    endcase
  end

  wire fin_pkt  = (accept && first == S_IDLE) || (endph && nxt == S_IDLE && !c_rec);
  wire fin_nak  = endph && nxt == S_IDLE && !c_rec && nak;
  wire fin_rok  = endph && st == S_STOP && c_rec;
  wire fin_rbad = endph && st == S_REC && nxt == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; shreg <= '0; dbuf <= '0;
      samp <= 1'b1; in_addr <= 1'b0; nak <= 1'b0; bb <= 1'b0;
      c_tx <= 1'b0; c_rx <= 1'b0; c_last <= 1'b0; c_stop <= 1'b0; c_rec <= 1'b0;
      rcnt <= '0;
    end else begin
      if (buf_we) dbuf <= buf_wdata;
      if (accept) begin
        st <= first; ph <= '0; bitn <= '0; nak <= 1'b0; rcnt <= '0;
        c_tx <= f_tx; c_rx <= f_rx; c_last <= cmd_word[10];
        c_stop <= f_stop; c_rec <= f_rec; in_addr <= f_start;
        shreg <= f_start ? {cmd_word[6:0], f_rx} : dbuf;
      end else if (adv) begin
        ph <= ph + 2'd1;
        if (ph == 2'd2) begin
          samp <= sda_q;
          if (st == S_ACK && (in_addr || c_tx) && sda_q) nak <= 1'b1;
        end
        if (ph == 2'd3) begin
          st <= nxt;
          case (st)
            S_START: begin bb <= 1'b1; bitn <= '0; end
            S_BIT:   begin bitn <= bitn + 3'd1; shreg <= {shreg[6:0], samp}; end
            S_ACK: begin
              bitn <= '0;
              if (in_addr) begin
                in_addr <= 1'b0;
                if (nxt == S_BIT && c_tx) shreg <= dbuf;
              end else if (c_rx) dbuf <= shreg;
            end
            S_STOP:  bb <= 1'b0;
            S_REC:   rcnt <= rcnt + 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_done <= 1'b0; sts_nak <= 1'b0; sts_rec_ok <= 1'b0; sts_rec_fail <= 1'b0;
    end else begin
      if (fin_pkt) sts_done <= 1'b1;
      else if (sts_clr_we && sts_clr_mask[0]) sts_done <= 1'b0;
      if (fin_nak) sts_nak <= 1'b1;
      else if (sts_clr_we && sts_clr_mask[1]) sts_nak <= 1'b0;
      if (fin_rok) sts_rec_ok <= 1'b1;
      else if (sts_clr_we && sts_clr_mask[2]) sts_rec_ok <= 1'b0;
      if (fin_rbad) sts_rec_fail <= 1'b1;
      else if (sts_clr_we && sts_clr_mask[3]) sts_rec_fail <= 1'b0;
    end
  end

  always_comb begin
    scl_drive_low = 1'b0;
    sda_drive_low = 1'b0;
    case (st)
      S_IDLE:  scl_drive_low = bb;
      S_START: begin
        scl_drive_low = (ph == 2'd0) || (ph == 2'd3);
        sda_drive_low = ph[1];
      end
      S_BIT: begin
        scl_drive_low = (ph == 2'd0) || (ph == 2'd3);
        sda_drive_low = (in_addr || c_tx) && !shreg[7];
      end
      S_ACK: begin
        scl_drive_low = (ph == 2'd0) || (ph == 2'd3);
        sda_drive_low = !in_addr && c_rx && !c_last;
      end
      S_STOP: begin
        scl_drive_low = ph == 2'd0;
        sda_drive_low = !ph[1];
      end
      S_REC:   scl_drive_low = ph == 2'd0;
      default: ;
    endcase
  end

  assign buf_rdata   = dbuf;
  assign bus_busy    = bb;
  assign engine_busy = st != S_IDLE;
  assign scl_level   = scl_q;
  assign sda_level   = sda_q;
endmodule

// File: rtl/i2c_pkt_master_chk.sv
module i2c_pkt_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       sts_done,
  input logic       sts_nak,
  input logic       sts_rec_ok,
  input logic       sts_rec_fail,
  input logic       bus_busy,
  input logic       engine_busy,
  input logic       scl_drive_low,
  input logic       sda_drive_low
);
  localparam logic [2:0] S_START = 3'd1, S_STOP = 3'd4;

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_done) |-> !engine_busy);

  a_r6_nak_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_nak) |-> sts_done);

  a_r7_hold_keeps_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !engine_busy) |-> scl_drive_low);

  a_r8_sda_moves_with_scl_high_only_at_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !$past(scl_drive_low) && (sda_drive_low != $past(sda_drive_low)))
      |-> (st == S_START || st == S_STOP));

  a_r10_recovered_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rec_ok) |-> !bus_busy && !engine_busy);

  a_r11_fail_releases_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rec_fail) |-> !scl_drive_low && !sda_drive_low);

  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && !engine_busy) |-> !scl_drive_low && !sda_drive_low);
endmodule

bind i2c_pkt_master i2c_pkt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st),
  .sts_done(sts_done), .sts_nak(sts_nak), .sts_rec_ok(sts_rec_ok),
  .sts_rec_fail(sts_rec_fail), .bus_busy(bus_busy), .engine_busy(engine_busy),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_pkt_master_tb.sv
`timescale 1ns/1ps
module i2c_pkt_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_tick = 1'b0;
  logic cmd_we = 1'b0, buf_we = 1'b0, sts_clr_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0] buf_wdata = '0;
  logic [3:0] sts_clr_mask = '0;
  logic [7:0] buf_rdata;
  logic sts_done, sts_nak, sts_rec_ok, sts_rec_fail, bus_busy, engine_busy;
  logic scl_level, sda_level, scl_drive_low, sda_drive_low;
  logic scl_w, sda_w;

  int total = 0, bad = 0;
  bit finished = 0;

  // target model state
  localparam logic [6:0] TADDR = 7'h50;
  logic slv_low = 1'b0;
  bit   started = 0, in_addr = 0, sel = 0, rd = 0, p_scl = 1, p_sda = 1;
  int   bitcnt = 0, starts = 0, stops = 0, rises = 0, wr_n = 0, mack_n = 0, rd_cnt = 0;
  logic [7:0] sh = '0, last_addr = '0, cur = '0;
  logic [7:0] wr_log [16];
  logic       mack_log [16];
  logic [7:0] rd_bytes [2];
  bit   nack_data = 0, stuck_on = 0;
  int   stuck_base = 0, stuck_n = 0;
  wire  stuck_w = stuck_on && ((rises - stuck_base) < stuck_n);

  assign scl_w = ~scl_drive_low;
  assign sda_w = ~(sda_drive_low | slv_low | stuck_w);

  i2c_pkt_master u_dut (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick),
    .cmd_we(cmd_we), .cmd_word(cmd_word), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
    .sts_done(sts_done), .sts_nak(sts_nak), .sts_rec_ok(sts_rec_ok),
    .sts_rec_fail(sts_rec_fail), .bus_busy(bus_busy), .engine_busy(engine_busy),
    .scl_level(scl_level), .sda_level(sda_level), .scl_i(scl_w), .sda_i(sda_w),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  always #5 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    phase_tick <= (tcnt == 3);
  end

  always @(scl_w or sda_w) begin
    if (rst_n) begin
      if (sda_w !== p_sda && scl_w && p_scl) begin
        if (!sda_w) begin
          starts++; started = 1; bitcnt = 0; in_addr = 1; sel = 0; rd = 0; slv_low = 0;
        end else begin
          stops++; started = 0; slv_low = 0;
        end
      end
      if (scl_w && !p_scl) begin
        rises++;
        if (started) begin
          if (bitcnt < 8) sh = {sh[6:0], sda_w};
          else if (bitcnt == 8 && rd && sel && !in_addr) begin
            mack_log[mack_n & 15] = sda_w; mack_n++;
          end
          bitcnt++;
        end
      end
      if (!scl_w && p_scl && started) begin
        if (bitcnt == 8) begin
          if (in_addr) begin
            last_addr = sh; sel = (sh[7:1] == TADDR); rd = sh[0]; slv_low = sel;
          end else if (!rd && sel) begin
            wr_log[wr_n & 15] = sh; wr_n++; slv_low = !nack_data;
          end else slv_low = 0;
        end else if (bitcnt == 9) begin
          bitcnt = 0; slv_low = 0;
          if (rd && sel && (in_addr || mack_log[(mack_n - 1) & 15] == 1'b0)) begin
            cur = rd_bytes[rd_cnt & 1]; rd_cnt++; slv_low = ~cur[7];
          end else if (rd) sel = 0;
          in_addr = 0;
        end else if (rd && sel && !in_addr && bitcnt < 8) slv_low = ~cur[7 - bitcnt];
      end
    end
    p_scl = scl_w; p_sda = sda_w;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [6:0] a, input bit s, input bit tx,
                                     input bit rx, input bit last, input bit sp, input bit rec);
    return {1'b1, 2'b00, rec, sp, last, rx, tx, s, a};
  endfunction

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk); cmd_word = w; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
    for (int i = 0; i < 5000 && engine_busy; i++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk); buf_wdata = b; buf_we = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk); sts_clr_mask = m; sts_clr_we = 1'b1;
    @(negedge clk); sts_clr_we = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({sts_done, sts_nak, sts_rec_ok, sts_rec_fail} == 4'b0, "R5 reset status", sts_done, 0);
    chk(!scl_drive_low && !sda_drive_low, "R12 reset lines released", scl_drive_low, 0);
    chk(scl_level && sda_level, "R12 line levels high", {scl_level, sda_level}, 3);
    chk(!bus_busy && !engine_busy, "R8 reset not busy", bus_busy, 0);
  endtask

  task automatic t_ignored;
    int r0 = rises;
    @(negedge clk); cmd_word = mk(TADDR, 1, 1, 0, 0, 1, 0) & 16'h7fff; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
    repeat (200) @(negedge clk);
    chk(rises == r0 && !engine_busy, "R1 disabled command no bus activity", rises - r0, 0);
    chk(!sts_done, "R1 disabled command no status", sts_done, 0);
  endtask

  task automatic t_probe;
    int s0 = starts, p0 = stops, w0 = wr_n;
    send_cmd(mk(TADDR, 1, 0, 0, 0, 0, 0));
    chk(sts_done && !sts_nak, "R3 probe done without nak", {sts_done, sts_nak}, 2);
    chk(last_addr == 8'hA0, "R2 probe address byte rw=0", last_addr, 8'hA0);
    chk(starts == s0 + 1 && wr_n == w0, "R3 probe one start no data", wr_n - w0, 0);
    chk(stops == p0 && bus_busy && scl_drive_low, "R7 no stop, scl held", bus_busy, 1);
    clr(4'b0001);
    chk(!sts_done, "R5 done cleared by write one", sts_done, 0);
  endtask

  task automatic t_write;
    int s0 = starts, p0 = stops, w0 = wr_n;
    load(8'h3C);
    send_cmd(mk(TADDR, 1, 1, 0, 0, 0, 0));
    chk(bus_busy, "R8 busy between start and stop", bus_busy, 1);
    load(8'hC3);
    send_cmd(mk(TADDR, 0, 1, 0, 0, 1, 0));
    chk(starts == s0 + 1, "R2 second byte without start", starts - s0, 1);
    chk(wr_n == w0 + 2 && wr_log[w0 & 15] == 8'h3C, "R4 first written byte", wr_log[w0 & 15], 8'h3C);
    chk(wr_log[(w0 + 1) & 15] == 8'hC3, "R4 second written byte", wr_log[(w0 + 1) & 15], 8'hC3);
    chk(stops == p0 + 1 && !bus_busy, "R8 stop ends busy", bus_busy, 0);
    chk(sts_done && !sts_nak, "R5 write done", {sts_done, sts_nak}, 2);
    clr(4'b0011);
  endtask

  task automatic t_read;
    int m0 = mack_n;
    rd_bytes[0] = 8'hA5; rd_bytes[1] = 8'h5A;
    send_cmd(mk(TADDR, 1, 0, 1, 0, 0, 0));
    chk(last_addr == 8'hA1, "R2 read address rw=1", last_addr, 8'hA1);
    chk(buf_rdata == 8'hA5, "R4 first read byte", buf_rdata, 8'hA5);
    send_cmd(mk(TADDR, 0, 0, 1, 1, 1, 0));
    chk(buf_rdata == 8'h5A, "R4 last read byte", buf_rdata, 8'h5A);
    chk(mack_n == m0 + 2 && mack_log[m0 & 15] == 1'b0, "R9 ack on non-last byte", mack_log[m0 & 15], 0);
    chk(mack_log[(m0 + 1) & 15] == 1'b1, "R9 nack on last byte", mack_log[(m0 + 1) & 15], 1);
    chk(!bus_busy, "R7 stop after last read", bus_busy, 0);
    clr(4'b0011);
  endtask

  task automatic t_nak;
    int p0 = stops, w0 = wr_n;
    load(8'h66);
    send_cmd(mk(7'h33, 1, 1, 0, 0, 1, 0));
    chk(sts_done && sts_nak, "R6 address nak with done", {sts_done, sts_nak}, 3);
    chk(wr_n == w0 && rises > 0, "R6 data skipped after address nak", wr_n - w0, 0);
    chk(stops == p0 + 1 && !bus_busy, "R6 stop still issued", stops - p0, 1);
    clr(4'b0001);
    chk(!sts_done && sts_nak, "R5 clear leaves other bits", {sts_done, sts_nak}, 1);
    clr(4'b0010);
    chk(!sts_nak, "R5 nak cleared", sts_nak, 0);
    nack_data = 1;
    load(8'h77);
    send_cmd(mk(TADDR, 1, 1, 0, 0, 1, 0));
    chk(sts_nak && wr_n == w0 + 1, "R6 data byte nak", sts_nak, 1);
    nack_data = 0;
    clr(4'b0011);
  endtask

  task automatic t_rec_ok;
    stuck_base = rises; stuck_n = 3; stuck_on = 1;
    repeat (4) @(negedge clk);
    chk(!sda_level && scl_level, "R12 stuck sda visible", sda_level, 0);
    send_cmd(mk(7'h00, 0, 0, 0, 0, 0, 1));
    chk(sts_rec_ok && !sts_rec_fail, "R10 recovered", {sts_rec_ok, sts_rec_fail}, 2);
    chk(rises - stuck_base == 4, "R10 three pulses then stop", rises - stuck_base, 4);
    chk(!sts_done && sda_level && scl_level, "R10 bus free, no packet done", sts_done, 0);
    stuck_on = 0;
    clr(4'b0100);
  endtask

  task automatic t_rec_fail;
    stuck_base = rises; stuck_n = 1000; stuck_on = 1;
    repeat (4) @(negedge clk);
    send_cmd(mk(7'h00, 0, 0, 0, 0, 0, 1));
    chk(sts_rec_fail && !sts_rec_ok, "R11 recovery failed", {sts_rec_ok, sts_rec_fail}, 1);
    chk(rises - stuck_base == 9, "R11 nine pulses", rises - stuck_base, 9);
    chk(!scl_drive_low && !sda_drive_low && scl_level, "R11 lines released", scl_drive_low, 0);
    stuck_on = 0;
    clr(4'b1000);
    chk(!sts_rec_fail, "R5 rec fail cleared", sts_rec_fail, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ignored();
    t_probe();
    t_write();
    t_read();
    t_nak();
    t_rec_ok();
    t_rec_fail();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule